// File: doc/BRIEF.md
# I2C Register-Access Slave with Clock Stretching

This block is the I2C slave front end of a device whose internal register core answers slowly. The slave answers to one of three write/read device address pairs, picked by a three-state select that pad logic hands over as a 2-bit code. Each bus access uses a fixed frame. First comes the write device address, then a one-byte subaddress, then a 16-bit register address. After that a write carries 16 bits of data. A read sends a repeated start and the read device address, and the slave then returns 16 bits.

Subaddresses that reach the back end are 0x10 to 0x13. The slave forwards each such access through a request/ready handshake. It holds SCL low while the back end works. A subaddress of 0x00 selects a local control/status word that holds a reset-seen flag (bit 15) and a hardware-error flag (bit 14).

A wait counter bounds the stretching. When it runs out, the slave lets go of both bus lines, sets the error flag and leaves every remaining acknowledge of the transaction high. A write to the control word with bit 15 set performs a software reset of the core. Both bus lines are open-drain, so they appear as output enables that pull the line low. The inputs are passed through two flip-flops before edges are detected.

Top module: `i2c_regacc_slave`

## Requirements
- R1: `addr_sel_i` 00 selects device write/read addresses 0x80/0x81, 01 selects 0x84/0x85, 10 selects 0x88/0x89, and 11 answers no address. A device byte that does not match leaves its acknowledge high, and the slave stays silent until the next start.
- R2: Bytes travel MSB first and 16-bit fields travel high byte first. A write frame is device address, subaddress, address high, address low, data high, data low. Each byte is acknowledged by SDA low in the ninth clock.
- R3: A write to subaddress 0x10, 0x11, 0x12 or 0x13 issues exactly one back-end request with `req_we_o`=1, carrying the subaddress, address and data. The request is issued after the data-low byte.
- R4: A request stays high with a stable payload until `req_ready_i`. During that time SCL is held low, so the stretch lasts at least as many cycles as the back end takes. The acknowledge follows the handshake.
- R5: A read, made with a repeated start and the read address on a back-end subaddress, issues one request with `req_we_o`=0 and returns `req_rdata_i` high byte first. The low byte is sent only if the master acknowledged the high byte; otherwise SDA stays released and reads 0xFF.
- R6: A request not answered in `TMO_CYC` cycles of stretching is dropped. SCL and SDA are then released, about `TMO_CYC` cycles after the stretch began.
- R7: After a timeout, every acknowledge until the next STOP stays high, including the one after a repeated start, and control bit 14 becomes 1. The next transaction after the STOP is acknowledged normally.
- R8: A read of subaddress 0x00 returns {bit15 reset-seen, bit14 error, 14 zero bits} without a back-end request.
- R9: Bit 15 is 1 after `rst_ni`. A read of subaddress 0x00 returns the flag and then clears it.
- R10: A write of data with bit 15 set to subaddress 0x00 pulses `core_rst_o` for one cycle, sets bit 15 and clears bit 14. With data bit 15 clear the write has no effect.
- R11: For a subaddress outside {0x00, 0x10..0x13}, a read returns 0xFFFF and a write leaves both data acknowledges high. Neither makes a request.
- R12: Any byte after the data-low byte of a write is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel_i | input | 2 | Address-select code: 00 low, 01 high, 10 open |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| req_o | output | 1 | Back-end request |
| req_we_o | output | 1 | Request is a write |
| req_sub_o | output | 8 | Subaddress of the request |
| req_addr_o | output | 16 | Register address |
| req_wdata_o | output | 16 | Write data |
| req_ready_i | input | 1 | Back end finished the request |
| req_rdata_i | input | 16 | Read data, valid with ready |
| core_rst_o | output | 1 | One-cycle software reset pulse to the core |

## Verification
An acknowledge or read bit reaches the bus two to four clocks after a SCL edge: two synchronizer flops and one state register. The bench master therefore changes SDA only a quarter bit after pulling SCL low. It samples only a quarter bit after it has seen SCL actually high, and that wait also absorbs any stretch. Request fields are captured by a back-end model at the handshake cycle itself. Stretch length is measured as the longest run of consecutive cycles with `scl_oe_o` high, and its bounds are compared with the latency or with `TMO_CYC`. Flags and the reset pulse are read through later bus reads or counted per transaction, never sampled at a single edge.

// File: rtl/i2c_regacc_pkg.sv
package i2c_regacc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_PROC,
    ST_WAIT,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;

  localparam logic [7:0] SUB_CTRL   = 8'h00;
  localparam logic [7:0] SUB_DEM_WR = 8'h10;
  localparam logic [7:0] SUB_DEM_RD = 8'h11;
  localparam logic [7:0] SUB_DSP_WR = 8'h12;
  localparam logic [7:0] SUB_DSP_RD = 8'h13;

  localparam logic [15:0] UNMAPPED_RD = 16'hFFFF;

  function automatic logic sub_is_core(input logic [7:0] s);
    return (s == SUB_DEM_WR) || (s == SUB_DEM_RD) || (s == SUB_DSP_WR) || (s == SUB_DSP_RD);
  endfunction

  // write address of each select code; 2'b11 is filtered separately
  function automatic logic [7:0] dev_wr_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'h80;
      2'b01:   return 8'h84;
      default: return 8'h88;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer #(
  parameter int unsigned TMO_CYC = 90000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tmo_o
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tmo_o = run_i && (cnt_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!tmo_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_TMO_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CW'(TMO_CYC))); // R6

endmodule

// File: rtl/i2c_ctrl_flags.sv
module i2c_ctrl_flags (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        rd_i,
  input  logic        err_i,
  output logic [15:0] flags_o,
  output logic        core_rst_o
);
  logic rst_seen_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_seen_q <= 1'b1;
      err_q      <= 1'b0;
      core_rst_o <= 1'b0;
    end else begin
      core_rst_o <= srst_i;
      if (srst_i) begin
        rst_seen_q <= 1'b1;
        err_q      <= 1'b0;
      end else begin
        if (rd_i)  rst_seen_q <= 1'b0;
        if (err_i) err_q      <= 1'b1;
      end
    end
  end

  assign flags_o = {rst_seen_q, err_q, 14'b0};

  AST_SRST_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (flags_o[15] && !flags_o[14] && core_rst_o)); // R10
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !srst_i) |=> !flags_o[15]); // R9

endmodule

// File: rtl/i2c_regacc_fsm.sv
module i2c_regacc_fsm
  import i2c_regacc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_h_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        sda_h_i,
  input  logic        sda_rise_i,
  input  logic        sda_fall_i,
  input  logic [1:0]  addr_sel_i,
  input  logic        tmo_i,
  output logic        wait_o,
  input  logic [15:0] flags_i,
  output logic        srst_o,
  output logic        flags_rd_o,
  output logic        err_o,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic        req_o,
  output logic        req_we_o,
  output logic [7:0]  req_sub_o,
  output logic [15:0] req_addr_o,
  output logic [15:0] req_wdata_o,
  input  logic        ready_i,
  input  logic [15:0] rdata_i
);
  st_e         st_q;
  logic [3:0]  bit_cnt_q;
  logic [2:0]  idx_q;
  logic [7:0]  rx_sh_q, tx_sh_q, tx_lo_q, sub_q;
  logic [15:0] addr_q, wdata_q;
  logic        ack_q, ack_hold_q, next_tx_q, tx_second_q, mack_q, err_mode_q;
  logic        req_q, req_we_q;

  logic        start_det, stop_det, addr_hit, sub_known;
  logic [15:0] local_rd;

  assign start_det = sda_fall_i && scl_h_i;
  assign stop_det  = sda_rise_i && scl_h_i;
  assign addr_hit  = (addr_sel_i != 2'b11) && (rx_sh_q[7:1] == dev_wr_addr(addr_sel_i)[7:1]);
  assign sub_known = sub_is_core(sub_q) || (sub_q == SUB_CTRL);
  assign local_rd  = (sub_q == SUB_CTRL) ? flags_i : UNMAPPED_RD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      bit_cnt_q   <= '0;
      idx_q       <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      tx_lo_q     <= '0;
      sub_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      ack_q       <= 1'b0;
      ack_hold_q  <= 1'b0;
      next_tx_q   <= 1'b0;
      tx_second_q <= 1'b0;
      mack_q      <= 1'b0;
      err_mode_q  <= 1'b0;
      req_q       <= 1'b0;
      req_we_q    <= 1'b0;
      srst_o      <= 1'b0;
      flags_rd_o  <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      srst_o     <= 1'b0;
      flags_rd_o <= 1'b0;
      err_o      <= 1'b0;
      ack_hold_q <= 1'b0;
      if (stop_det) begin
        st_q       <= ST_IDLE;
        err_mode_q <= 1'b0;
      end else if (start_det) begin
        st_q      <= ST_RX;
        bit_cnt_q <= '0;
        idx_q     <= '0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i) begin
              rx_sh_q   <= {rx_sh_q[6:0], sda_h_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (scl_fall_i && bit_cnt_q == 4'd8) st_q <= ST_PROC;
          end
          ST_PROC: begin
            st_q       <= ST_ACK;
            ack_hold_q <= 1'b1;
            ack_q      <= 1'b1;
            next_tx_q  <= 1'b0;
            if (err_mode_q) ack_q <= 1'b0;
            else begin
              case (idx_q)
                3'd0: begin
                  if (!addr_hit) st_q <= ST_IDLE;
                  else if (rx_sh_q[0]) begin
                    tx_second_q <= 1'b0;
                    if (sub_is_core(sub_q)) begin
                      st_q     <= ST_WAIT;
                      req_q    <= 1'b1;
                      req_we_q <= 1'b0;
                    end else begin
                      next_tx_q  <= 1'b1;
                      tx_sh_q    <= local_rd[15:8];
                      tx_lo_q    <= local_rd[7:0];
                      flags_rd_o <= (sub_q == SUB_CTRL);
                    end
                  end
                end
                3'd1: sub_q         <= rx_sh_q;
                3'd2: addr_q[15:8]  <= rx_sh_q;
                3'd3: addr_q[7:0]   <= rx_sh_q;
                3'd4: begin
                  wdata_q[15:8] <= rx_sh_q;
                  ack_q         <= sub_known;
                end
                3'd5: begin
                  wdata_q[7:0] <= rx_sh_q;
                  if (sub_q == SUB_CTRL) srst_o <= wdata_q[15];
                  else if (sub_is_core(sub_q)) begin
                    st_q     <= ST_WAIT;
                    req_q    <= 1'b1;
                    req_we_q <= 1'b1;
                  end else ack_q <= 1'b0;
                end
                default: ack_q <= 1'b0;
              endcase
            end
          end
          ST_WAIT: begin
            if (ready_i) begin
              req_q      <= 1'b0;
              ack_q      <= 1'b1;
              ack_hold_q <= 1'b1;
              st_q       <= ST_ACK;
              next_tx_q  <= !req_we_q;
              if (!req_we_q) begin
                tx_sh_q <= rdata_i[15:8];
                tx_lo_q <= rdata_i[7:0];
              end
            end else if (tmo_i) begin
              req_q      <= 1'b0;
              ack_q      <= 1'b0;
              ack_hold_q <= 1'b1;
              err_mode_q <= 1'b1;
              err_o      <= 1'b1;
              next_tx_q  <= 1'b0;
              st_q       <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (next_tx_q) st_q <= ST_TX;
              else begin
                st_q <= ST_RX;
                if (idx_q != 3'd6) idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) st_q <= ST_MACK;
              else begin
                tx_sh_q   <= {tx_sh_q[6:0], 1'b1};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) mack_q <= !sda_h_i;
            if (scl_fall_i) begin
              if (mack_q && !tx_second_q) begin
                tx_sh_q     <= tx_lo_q;
                tx_second_q <= 1'b1;
                bit_cnt_q   <= '0;
                st_q        <= ST_TX;
              end else st_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wait_o      = (st_q == ST_WAIT);
  assign scl_oe_o    = (st_q == ST_PROC) || (st_q == ST_WAIT) || ((st_q == ST_ACK) && ack_hold_q);
  assign sda_oe_o    = ((st_q == ST_ACK) && ack_q) || ((st_q == ST_TX) && !tx_sh_q[7]);
  assign req_o       = req_q;
  assign req_we_o    = req_we_q;
  assign req_sub_o   = sub_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i && !tmo_i) |=> req_o); // R4
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i) |=> ($stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_sub_o) && $stable(req_we_o))); // R4
  AST_REQ_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> scl_oe_o); // R4
  AST_TMO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && tmo_i && !ready_i) |-> ##2 (!scl_oe_o && !sda_oe_o && !req_o)); // R6
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mode_q |-> !sda_oe_o); // R7

endmodule

// File: rtl/i2c_regacc_slave.sv
module i2c_regacc_slave #(
  parameter int unsigned TMO_CYC     = 90000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_sel_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic        req_o,
  output logic        req_we_o,
  output logic [7:0]  req_sub_o,
  output logic [15:0] req_addr_o,
  output logic [15:0] req_wdata_o,
  input  logic        req_ready_i,
  input  logic [15:0] req_rdata_i,
  output logic        core_rst_o
);
  logic scl_h, scl_rise, scl_fall, sda_h, sda_rise, sda_fall;
  logic tmo, wait_run, srst, flags_rd, err_set;
  logic [15:0] flags;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i),
    .lvl_o(scl_h), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i),
    .lvl_o(sda_h), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_stretch_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(wait_run), .tmo_o(tmo)
  );

  i2c_ctrl_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .rd_i(flags_rd), .err_i(err_set),
    .flags_o(flags), .core_rst_o(core_rst_o)
  );

  i2c_regacc_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_h_i(scl_h), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_h_i(sda_h), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .addr_sel_i(addr_sel_i), .tmo_i(tmo), .wait_o(wait_run),
    .flags_i(flags), .srst_o(srst), .flags_rd_o(flags_rd), .err_o(err_set),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .req_o(req_o), .req_we_o(req_we_o), .req_sub_o(req_sub_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .ready_i(req_ready_i), .rdata_i(req_rdata_i)
  );

endmodule

// File: tb/i2c_regacc_slave_tb_top.sv
module i2c_regacc_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QT         = 8 * CLK_PERIOD;
  localparam int TMO        = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_bus, sda_bus;
  logic [1:0] addr_sel = 2'b10;
  logic scl_oe, sda_oe, req, req_we, core_rst;
  logic [7:0] req_sub;
  logic [15:0] req_addr, req_wdata;
  logic ready = 1'b0;
  logic [15:0] rdata = '0;

  int n_chk = 0, n_fail = 0;
  int lat = 0;
  bit never = 1'b0;
  int wcnt = 0, req_cnt = 0, rst_cnt = 0, run = 0, max_run = 0;
  logic last_we;
  logic [7:0] last_sub;
  logic [15:0] last_addr, last_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = ~(m_scl_lo | scl_oe);
  assign sda_bus = ~(m_sda_lo | sda_oe);

  i2c_regacc_slave #(.TMO_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .addr_sel_i(addr_sel),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .req_o(req), .req_we_o(req_we), .req_sub_o(req_sub),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .req_ready_i(ready), .req_rdata_i(rdata),
    .core_rst_o(core_rst)
  );

  // back-end model: read data = address xor 0xA5C3
  always @(posedge clk) begin
    ready <= 1'b0;
    if (req && !ready) begin
      if (!never && wcnt >= lat) begin
        ready      <= 1'b1;
        rdata      <= req_addr ^ 16'hA5C3;
        req_cnt    = req_cnt + 1;
        last_we    = req_we;
        last_sub   = req_sub;
        last_addr  = req_addr;
        last_wdata = req_wdata;
      end else wcnt = wcnt + 1;
    end else wcnt = 0;
    if (core_rst) rst_cnt = rst_cnt + 1;
    if (scl_oe) begin
      run = run + 1;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_scl_hi();
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_lo = 0; m_scl_lo = 0; #(QT); wait_scl_hi();
    m_sda_lo = 1; #(QT); m_scl_lo = 1; #(QT);
  endtask

  task automatic m_rstart();
    m_sda_lo = 0; #(QT); m_scl_lo = 0; wait_scl_hi(); #(QT);
    m_sda_lo = 1; #(QT); m_scl_lo = 1; #(QT);
  endtask

  task automatic m_stop();
    m_sda_lo = 1; #(QT); m_scl_lo = 0; wait_scl_hi(); #(QT);
    m_sda_lo = 0; #(QT);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_lo = !b; #(QT); m_scl_lo = 0; wait_scl_hi(); #(QT);
    r = sda_bus; #(QT); m_scl_lo = 1; #(QT);
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      v[i] = r;
    end
    m_bit(!give_ack, r);
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] sub, input logic [15:0] a,
                          input logic [15:0] d, output logic [5:0] acks);
    m_start();
    m_wbyte(dev, acks[0]); m_wbyte(sub, acks[1]);
    m_wbyte(a[15:8], acks[2]); m_wbyte(a[7:0], acks[3]);
    m_wbyte(d[15:8], acks[4]); m_wbyte(d[7:0], acks[5]);
    m_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] sub, input logic [15:0] a,
                         output logic [15:0] v, output logic [4:0] acks);
    m_start();
    m_wbyte(dev, acks[0]); m_wbyte(sub, acks[1]);
    m_wbyte(a[15:8], acks[2]); m_wbyte(a[7:0], acks[3]);
    m_rstart();
    m_wbyte(dev | 8'h01, acks[4]);
    m_rbyte(1'b1, v[15:8]); m_rbyte(1'b0, v[7:0]);
    m_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] wa;
    logic [4:0] ra;
    logic [15:0] rv;
    logic [7:0] b;
    logic a;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state: R4 no request, R9 flag set
    chk("R4 reset req", {29'b0, req, scl_oe, sda_oe}, 32'h0);
    chk("R10 reset core_rst", core_rst, 0);
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R8 ctrl read acks", ra, 5'h1F);
    chk("R9 ctrl after reset", rv, 16'h8000);
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R9 ctrl cleared by read", rv, 16'h0000);
    chk("R8 no req for ctrl", req_cnt, 0);

    // R1 address sweep: expected hit = sel!=3 && dev==0x80+4*sel
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] dv;
        dv = 8'h80 + 8'(2 * k);
        addr_sel = 2'(s);
        m_start(); m_wbyte(dv, a); m_stop();
        chk($sformatf("R1 sel %0d dev %0h", s, dv), a,
            (s != 3) && (dv == 8'h80 + 8'(4 * s)));
      end
    end
    addr_sel = 2'b10;

    // R2 R3 R4 writes to back end with several latencies
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 3; l++) begin
        logic [15:0] ad, dt;
        lat = (l == 0) ? 0 : (l == 1) ? 7 : 60;
        ad = 16'h1200 + 16'(s * 37 + l);
        dt = 16'hC35A ^ 16'(s * 4099 + l * 257);
        c0 = req_cnt; max_run = 0;
        do_write(8'h88, 8'h10 + 8'(s), ad, dt, wa);
        chk("R2 write acks", wa, 6'h3F);
        chk("R3 one request", req_cnt - c0, 1);
        chk("R3 we", last_we, 1);
        chk("R3 sub", last_sub, 8'h10 + 8'(s));
        chk("R3 addr", last_addr, ad);
        chk("R3 data", last_wdata, dt);
        chk("R4 stretch covers latency", max_run >= lat, 1);
      end
    end

    // R5 reads through the back end, also with select code 00
    for (int t = 0; t < 4; t++) begin
      logic [15:0] ad;
      ad = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : (t == 2) ? 16'h1234 : 16'h8001;
      lat = (t == 3) ? 40 : 0;
      addr_sel = (t == 2) ? 2'b00 : 2'b10;
      c0 = req_cnt;
      do_read((t == 2) ? 8'h80 : 8'h88, (t[0]) ? 8'h13 : 8'h11, ad, rv, ra);
      chk("R5 read acks", ra, 5'h1F);
      chk("R5 read data", rv, ad ^ 16'hA5C3);
      chk("R5 read we", last_we, 0);
      chk("R5 one request", req_cnt - c0, 1);
    end
    addr_sel = 2'b10; lat = 0;

    // R5 master NACKs the high byte: low byte not sent
    m_start(); m_wbyte(8'h88, a); m_wbyte(8'h11, a); m_wbyte(8'h00, a); m_wbyte(8'h3C, a);
    m_rstart(); m_wbyte(8'h89, a);
    m_rbyte(1'b0, b);
    chk("R5 high byte", b, 8'h00 ^ 8'hA5);
    m_rbyte(1'b0, b);
    chk("R5 no second byte after nack", b, 8'hFF);
    m_stop();

    // R6 R7 timeout
    never = 1'b1; max_run = 0;
    m_start(); m_wbyte(8'h88, a); m_wbyte(8'h12, a); m_wbyte(8'h00, a); m_wbyte(8'h42, a);
    m_wbyte(8'hBE, a);
    m_wbyte(8'hEF, a);
    chk("R7 nack on timed-out byte", a, 0);
    chk("R6 stretch at least TMO", max_run >= TMO, 1);
    chk("R6 stretch bounded", max_run <= TMO + 4, 1);
    chk("R6 request dropped", {req, scl_oe, sda_oe}, 3'b000);
    never = 1'b0;
    m_wbyte(8'h55, a);
    chk("R7 later byte nack", a, 0);
    m_rstart(); m_wbyte(8'h88, a);
    chk("R7 nack after repeated start", a, 0);
    m_stop();
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R7 ctrl error flag", rv, 16'h4000);
    chk("R7 next transaction acked", ra, 5'h1F);

    // R10 software reset
    c0 = rst_cnt;
    do_write(8'h88, 8'h00, 16'h0000, 16'h8000, wa);
    chk("R10 srst acks", wa, 6'h3F);
    chk("R10 core reset pulse", rst_cnt - c0, 1);
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R10 flags after srst", rv, 16'h8000);
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R9 cleared again", rv, 16'h0000);
    c0 = rst_cnt;
    do_write(8'h88, 8'h00, 16'h0000, 16'h7FFF, wa);
    chk("R10 no pulse without bit15", rst_cnt - c0, 0);
    do_read(8'h88, 8'h00, 16'h0000, rv, ra);
    chk("R10 flags unchanged", rv, 16'h0000);

    // R11 unmapped subaddress
    c0 = req_cnt;
    do_write(8'h88, 8'h20, 16'h0101, 16'h2222, wa);
    chk("R11 data bytes nacked", wa, 6'h0F);
    do_read(8'h88, 8'h20, 16'h0101, rv, ra);
    chk("R11 read value", rv, 16'hFFFF);
    chk("R11 no requests", req_cnt - c0, 0);

    // R12 extra byte after data-low
    m_start(); m_wbyte(8'h88, a); m_wbyte(8'h10, a); m_wbyte(8'h00, a); m_wbyte(8'h01, a);
    m_wbyte(8'h02, a); m_wbyte(8'h03, a);
    chk("R12 data-low acked", a, 1);
    m_wbyte(8'h04, a);
    chk("R12 extra byte nacked", a, 0);
    m_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule